// File: doc/BRIEF.md
# External Memory Bus Interface

This block turns single-byte read and write requests from the chip's interior into cycles on an external memory bus. Each accepted request runs an address phase, a strobe phase and a recovery phase. It drives a 20-bit address, four active-low chip selects, an address latch enable, a read strobe and two write-side strobe pins. The bus width, the address/data multiplexing and the write-strobe style come from static configuration inputs.

An external master may take the bus with an active-low hold request. The block grants it only between cycles, floats its outputs and answers with an active-low acknowledge. A slow device stretches the strobe phase by holding the active-low ready input low. The address ranges that select each chip select are fixed by a parameter table of inclusive low/high bounds.

Top module: `ext_bus_if`

## Requirements
- R1: With `cfg_byte_bus` = 1 (8-bit bus), write data and read data use pins 7:0 only. With `cfg_byte_bus` = 0 (16-bit bus), an even byte address uses pins 7:0 and an odd one uses pins 15:8. The unused lane is driven 0.
- R2: With `cfg_wr_bhe` = 0 and a 16-bit bus (separate byte-write style), a write drives `mem_wrl_n` low for an even address and `mem_wrh_n` low for an odd address. This happens during the strobe phase only, and the other pin stays high.
- R3: With `cfg_wr_bhe` = 1 (single-write style), a write drives `mem_wrl_n` low during the strobe phase. `mem_wrh_n` acts as byte-high enable: it is low in the address and strobe phases of any access to an odd address.
- R4: When `cfg_byte_bus` = 1, the single-write style of R3 applies whatever the value of `cfg_wr_bhe`.
- R5: A read drives `mem_rd_n` low during the strobe phase and returns the selected lane on `req_rdata` while `req_done` is high.
- R6: `mem_addr` carries the latched request address during a cycle. With `cfg_muxed` = 1, the address phase drives `mem_doe` high and places a byte on pins 7:0: address bits 7:0 on an 8-bit bus, or address bits 8:1 on a 16-bit bus.
- R7: `mem_ale` is high for exactly the one address-phase cycle, which begins one clock after the request is accepted. The strobe phase follows it directly.
- R8: While `hold_n` is low, a new cycle is not started. Any running cycle completes, and then `hlda_n` goes low with `mem_drive` low and every strobe, chip select and `mem_ale` inactive. Requests that arrive during the hold are not started.
- R9: `rdy_n` is sampled at the end of each strobe cycle. Every low sample adds one strobe cycle, so N low samples give N+1 strobe cycles.
- R10: At most one chip select is low, and only in the address and strobe phases. The default regions are: select 0 covers 30000h–FFFFFh, select 1 covers 28000h–2FFFFh, select 2 covers 08000h–27FFFh and select 3 covers 04000h–07FFFh. Below 04000h no select goes low.
- R11: After reset the bus is idle: strobes, `mem_ale` and `req_done` are inactive, all chip selects are high, `hlda_n` is high and `mem_drive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte_bus | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| cfg_muxed | input | 1 | 1 = address shares the low data pins |
| cfg_wr_bhe | input | 1 | 1 = single write plus byte-high enable style |
| req_valid | input | 1 | Request pending; held until `req_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_done | output | 1 | Recovery phase of the finished cycle |
| req_rdata | output | 8 | Read byte, valid with `req_done` |
| mem_addr | output | 20 | External address pins |
| mem_dout | output | 16 | Data/address out on the shared pins |
| mem_din | input | 16 | Data in from the shared pins |
| mem_doe | output | 1 | Output enable for `mem_dout` |
| mem_drive | output | 1 | 0 while the bus is released for hold |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_rd_n | output | 1 | Read strobe |
| mem_wrl_n | output | 1 | Low-byte write, or single write strobe |
| mem_wrh_n | output | 1 | High-byte write, or byte-high enable |
| mem_ale | output | 1 | Address latch enable |
| hold_n | input | 1 | Active-low bus hold request |
| hlda_n | output | 1 | Active-low hold acknowledge |
| rdy_n | input | 1 | Active-low ready; low inserts wait cycles |

## Verification
The embedded properties check on every cycle that the chip selects never overlap and that the hold acknowledge rises only from an idle bus with all controls released. They also check that the latch enable is a single cycle followed by the strobe phase, that a low ready sample keeps the strobe phase, and that a write on the 8-bit bus uses the single write strobe. Only the bench scenarios can show the values themselves. These are the lane chosen for each byte, the shifted multiplexed address, the strobe pin that fires for each address parity and style, the exact stretch for a given number of wait samples, the read byte returned, and the region boundaries of the address decode.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
    localparam int unsigned ADDR_W = 20;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned N_CS   = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_ADDR = 3'd2,
        ST_STRB = 3'd3,
        ST_REC  = 3'd4
    } bus_state_e;

    // Region bounds, select i at bits [i*ADDR_W +: ADDR_W], inclusive.
    localparam logic [N_CS*ADDR_W-1:0] CS_LO_DEF =
        {20'h04000, 20'h08000, 20'h28000, 20'h30000};
    localparam logic [N_CS*ADDR_W-1:0] CS_HI_DEF =
        {20'h07FFF, 20'h27FFF, 20'h2FFFF, 20'hFFFFF};
endpackage

// File: rtl/ebi_cs_decode.sv
module ebi_cs_decode #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned N_CS   = 4,
    parameter logic [N_CS*ADDR_W-1:0] RANGE_LO = ebi_pkg::CS_LO_DEF,
    parameter logic [N_CS*ADDR_W-1:0] RANGE_HI = ebi_pkg::CS_HI_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [N_CS-1:0]   sel
);
    logic [N_CS-1:0] hit;
    logic            found;

    for (genvar i = 0; i < N_CS; i++) begin : g_region
        assign hit[i] = (addr >= RANGE_LO[i*ADDR_W +: ADDR_W]) &&
                        (addr <= RANGE_HI[i*ADDR_W +: ADDR_W]);
    end

    // Lowest index wins if regions overlap.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < N_CS; i++) begin
            if (hit[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
        if (!en) sel = '0;
    end
endmodule

// File: rtl/ebi_lane.sv
module ebi_lane #(
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned LANE_W = BUS_W / 2
) (
    input  logic              byte_bus,
    input  logic              addr_phase,
    input  logic [LANE_W:0]   addr_lo,
    input  logic [LANE_W-1:0] wdata,
    input  logic [BUS_W-1:0]  din,
    output logic [BUS_W-1:0]  dout,
    output logic [LANE_W-1:0] rdata
);
    logic high_lane;
    assign high_lane = !byte_bus && addr_lo[0];

    always_comb begin
        dout = '0;
        if (addr_phase) begin
            // Byte-wide bus shows the raw low address; word-wide shows it shifted by one.
            dout[LANE_W-1:0] = byte_bus ? addr_lo[LANE_W-1:0] : addr_lo[LANE_W:1];
        end else if (high_lane) begin
            dout[BUS_W-1:LANE_W] = wdata;
        end else begin
            dout[LANE_W-1:0] = wdata;
        end
    end

    assign rdata = high_lane ? din[BUS_W-1:LANE_W] : din[LANE_W-1:0];
endmodule

// File: rtl/ext_bus_if.sv
module ext_bus_if #(
    parameter int unsigned ADDR_W = ebi_pkg::ADDR_W,
    parameter int unsigned BUS_W  = ebi_pkg::BUS_W,
    parameter int unsigned N_CS   = ebi_pkg::N_CS,
    parameter logic [N_CS*ADDR_W-1:0] CS_LO = ebi_pkg::CS_LO_DEF,
    parameter logic [N_CS*ADDR_W-1:0] CS_HI = ebi_pkg::CS_HI_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_byte_bus,
    input  logic                cfg_muxed,
    input  logic                cfg_wr_bhe,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BUS_W/2-1:0]  req_wdata,
    output logic                req_done,
    output logic [BUS_W/2-1:0]  req_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BUS_W-1:0]    mem_dout,
    input  logic [BUS_W-1:0]    mem_din,
    output logic                mem_doe,
    output logic                mem_drive,
    output logic [N_CS-1:0]     mem_cs_n,
    output logic                mem_rd_n,
    output logic                mem_wrl_n,
    output logic                mem_wrh_n,
    output logic                mem_ale,
    input  logic                hold_n,
    output logic                hlda_n,
    input  logic                rdy_n
);
    import ebi_pkg::*;

    localparam int unsigned LANE_W = BUS_W / 2;

    typedef struct packed {
        bus_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [LANE_W-1:0]   wdata;
        logic                wr;
        logic [LANE_W-1:0]   rdata;
    } regs_t;

    regs_t d, q;

    logic [BUS_W-1:0]  lane_dout;
    logic [LANE_W-1:0] lane_rdata;
    logic [N_CS-1:0]   cs_sel;
    logic              in_cyc;
    logic              in_strb;
    logic              sep_style;
    logic              odd;

    assign in_cyc    = (q.st == ST_ADDR) || (q.st == ST_STRB);
    assign in_strb   = (q.st == ST_STRB);
    assign sep_style = !cfg_wr_bhe && !cfg_byte_bus;
    assign odd       = q.addr[0];

    ebi_cs_decode #(
        .ADDR_W  (ADDR_W),
        .N_CS    (N_CS),
        .RANGE_LO(CS_LO),
        .RANGE_HI(CS_HI)
    ) cs_dec_i (
        .addr(q.addr),
        .en  (in_cyc),
        .sel (cs_sel)
    );

    ebi_lane #(
        .BUS_W (BUS_W),
        .LANE_W(LANE_W)
    ) lane_i (
        .byte_bus  (cfg_byte_bus),
        .addr_phase(q.st == ST_ADDR),
        .addr_lo   (q.addr[LANE_W:0]),
        .wdata     (q.wdata),
        .din       (mem_din),
        .dout      (lane_dout),
        .rdata     (lane_rdata)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (!hold_n) begin
                    d.st = ST_HOLD;
                end else if (req_valid) begin
                    d.st    = ST_ADDR;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.wr    = req_write;
                end
            end
            ST_HOLD: if (hold_n) d.st = ST_IDLE;
            ST_ADDR: d.st = ST_STRB;
            ST_STRB: begin
                if (rdy_n) begin
                    d.st = ST_REC;
                    if (!q.wr) d.rdata = lane_rdata;
                end
            end
            ST_REC:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_done  = (q.st == ST_REC);
    assign req_rdata = q.rdata;
    assign mem_ale   = (q.st == ST_ADDR);
    assign mem_drive = (q.st != ST_HOLD);
    assign hlda_n    = (q.st != ST_HOLD);
    assign mem_addr  = (q.st == ST_HOLD) ? '0 : q.addr;
    assign mem_cs_n  = ~cs_sel;
    assign mem_rd_n  = !(in_strb && !q.wr);
    assign mem_wrl_n = sep_style ? !(in_strb && q.wr && !odd) : !(in_strb && q.wr);
    assign mem_wrh_n = sep_style ? !(in_strb && q.wr && odd)  : !(in_cyc && odd);
    assign mem_doe   = ((q.st == ST_ADDR) && cfg_muxed) ||
                       ((in_strb || (q.st == ST_REC)) && q.wr);
    assign mem_dout  = mem_doe ? lane_dout : '0;

    // R10: selects never overlap
    a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R8: released bus shows no activity
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n |-> (mem_rd_n && mem_wrl_n && mem_wrh_n && (&mem_cs_n) && !mem_ale && !mem_drive));

    // R8: grant only from an idle bus
    a_r8_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_n) |-> ($past(q.st) == ST_IDLE));

    // R7: latch enable is one cycle and leads straight into the strobe phase
    a_r7_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ale |=> (!mem_ale && q.st == ST_STRB));

    // R9: a low ready sample keeps the strobe phase
    a_r9_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strb && !rdy_n) |=> (in_strb && $stable(mem_rd_n) && $stable(mem_wrl_n)));

    // R4: 8-bit bus writes use the single write strobe
    a_r4_byte_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_byte_bus && in_strb && q.wr) |-> !mem_wrl_n);
endmodule

// File: tb/ext_bus_if_tb.sv
module ext_bus_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_byte_bus = 1'b0, cfg_muxed = 1'b0, cfg_wr_bhe = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_done;
    logic [7:0]  req_rdata;
    logic [19:0] mem_addr;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = '0;
    logic        mem_doe, mem_drive;
    logic [3:0]  mem_cs_n;
    logic        mem_rd_n, mem_wrl_n, mem_wrh_n, mem_ale;
    logic        hold_n = 1'b1;
    logic        hlda_n;
    logic        rdy_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ext_bus_if dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_byte_bus(cfg_byte_bus), .cfg_muxed(cfg_muxed), .cfg_wr_bhe(cfg_wr_bhe),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_doe(mem_doe), .mem_drive(mem_drive), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_wrl_n(mem_wrl_n), .mem_wrh_n(mem_wrh_n),
        .mem_ale(mem_ale), .hold_n(hold_n), .hlda_n(hlda_n), .rdy_n(rdy_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs_n(input logic [19:0] a);
        if (a >= 20'h30000)      return 4'b1110;
        else if (a >= 20'h28000) return 4'b1101;
        else if (a >= 20'h08000) return 4'b1011;
        else if (a >= 20'h04000) return 4'b0111;
        else                     return 4'b1111;
    endfunction

    function automatic logic [7:0] exp_mux(input logic [19:0] a, input logic bb);
        return bb ? a[7:0] : a[8:1];
    endfunction

    function automatic logic [15:0] exp_lane(input logic [19:0] a, input logic [7:0] v, input logic bb);
        return (!bb && a[0]) ? {v, 8'h00} : {8'h00, v};
    endfunction

    // Starts just after a negedge with the bus idle.
    task automatic access(input logic wr, input logic [19:0] a, input logic [7:0] v,
                          input int waits, input logic hold_mid);
        logic [15:0] din_v;
        logic sep;
        int strb;
        string stag;
        din_v = 16'($urandom);
        mem_din   = din_v;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = v;
        sep  = !cfg_wr_bhe && !cfg_byte_bus;
        stag = !wr ? "R5" : (cfg_byte_bus ? "R4" : (sep ? "R2" : "R3"));
        @(negedge clk); // address phase
        chk("R7 ale in address phase", 32'(mem_ale), 32'd1);
        chk("R10 select in address phase", 32'(mem_cs_n), 32'(exp_cs_n(a)));
        chk("R6 address pins", 32'(mem_addr), 32'(a));
        chk("R3 byte-high enable in address phase", 32'(mem_wrh_n), 32'(sep ? 1'b1 : !a[0]));
        if (cfg_muxed) begin
            chk("R6 multiplexed address byte", 32'(mem_dout[7:0]), 32'(exp_mux(a, cfg_byte_bus)));
            chk("R6 multiplexed drive", 32'(mem_doe), 32'd1);
        end
        req_valid = 1'b0;
        if (hold_mid) hold_n = 1'b0;
        strb = 0;
        forever begin
            @(negedge clk);
            if (req_done || strb > waits + 4) break;
            strb++;
            chk("R7 ale low in strobe", 32'(mem_ale), 32'd0);
            chk({stag, " read strobe"}, 32'(mem_rd_n), 32'(wr));
            chk({stag, " low write pin"}, 32'(mem_wrl_n), 32'(wr ? (sep ? a[0] : 1'b0) : 1'b1));
            chk({stag, " high write pin"}, 32'(mem_wrh_n), 32'(sep ? (wr ? !a[0] : 1'b1) : !a[0]));
            chk("R10 select in strobe", 32'(mem_cs_n), 32'(exp_cs_n(a)));
            if (hold_mid) chk("R8 no grant mid-cycle", 32'(hlda_n), 32'd1);
            if (wr) chk("R1 write lane", 32'(mem_dout), 32'(exp_lane(a, v, cfg_byte_bus)));
            rdy_n = (strb <= waits) ? 1'b0 : 1'b1;
        end
        rdy_n = 1'b1;
        chk("R9 strobe length", 32'(strb), 32'(waits + 1));
        chk("R9 done reached", 32'(req_done), 32'd1);
        chk("R10 selects released in recovery", 32'(mem_cs_n), 32'hF);
        if (!wr)
            chk("R5 R1 read byte", 32'(req_rdata),
                32'((!cfg_byte_bus && a[0]) ? din_v[15:8] : din_v[7:0]));
        @(negedge clk); // idle
        if (hold_mid) begin
            @(negedge clk);
            chk("R8 hold granted after cycle", 32'(hlda_n), 32'd0);
            chk("R8 bus released", 32'(mem_drive), 32'd0);
            hold_n = 1'b1;
            @(negedge clk);
            chk("R8 hold acknowledge removed", 32'(hlda_n), 32'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [19:0] bnd [8];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ale", 32'(mem_ale), 32'd0);
        chk("R11 read strobe", 32'(mem_rd_n), 32'd1);
        chk("R11 write pins", 32'({mem_wrl_n, mem_wrh_n}), 32'd3);
        chk("R11 selects", 32'(mem_cs_n), 32'hF);
        chk("R11 hold ack", 32'(hlda_n), 32'd1);
        chk("R11 drive", 32'(mem_drive), 32'd1);
        chk("R11 done", 32'(req_done), 32'd0);

        // R2: separate byte-write style, 16-bit
        cfg_byte_bus = 0; cfg_muxed = 0; cfg_wr_bhe = 0;
        access(1'b1, 20'h30010, 8'hA5, 0, 1'b0);
        access(1'b1, 20'h30011, 8'h5A, 2, 1'b0);
        access(1'b0, 20'h30013, 8'h00, 0, 1'b0);
        // R3: single write + byte-high enable
        cfg_wr_bhe = 1;
        access(1'b1, 20'h28001, 8'h3C, 1, 1'b0);
        access(1'b0, 20'h28001, 8'h00, 0, 1'b0);
        access(1'b0, 20'h28002, 8'h00, 3, 1'b0);
        // R4: 8-bit bus forces single-write style even with cfg_wr_bhe low
        cfg_byte_bus = 1; cfg_wr_bhe = 0;
        access(1'b1, 20'h08003, 8'hC3, 0, 1'b0);
        access(1'b0, 20'h08005, 8'h00, 1, 1'b0);
        // R6: multiplexed address on both widths
        cfg_muxed = 1;
        access(1'b1, 20'h2A5B7, 8'h11, 0, 1'b0);
        cfg_byte_bus = 0;
        access(1'b0, 20'h2A5B7, 8'h00, 0, 1'b0);
        access(1'b1, 20'h301FE, 8'h22, 2, 1'b0);
        cfg_muxed = 0;
        // R10: region boundaries
        bnd[0] = 20'h03FFF; bnd[1] = 20'h04000; bnd[2] = 20'h07FFF; bnd[3] = 20'h08000;
        bnd[4] = 20'h27FFF; bnd[5] = 20'h28000; bnd[6] = 20'h2FFFF; bnd[7] = 20'hFFFFF;
        for (int i = 0; i < 8; i++) access(1'b0, bnd[i], 8'h00, 0, 1'b0);
        // R8: hold from idle ignores a pending request
        hold_n = 1'b0;
        @(negedge clk);
        chk("R8 grant from idle", 32'(hlda_n), 32'd0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h30000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 request ignored in hold", 32'({mem_ale, mem_wrl_n, mem_drive}), 32'b010);
        end
        req_valid = 1'b0;
        hold_n = 1'b1;
        @(negedge clk);
        chk("R8 release", 32'(hlda_n), 32'd1);
        // R8: hold raised during a cycle
        access(1'b1, 20'h30020, 8'h77, 1, 1'b1);
        // Random mix
        for (int k = 0; k < 60; k++) begin
            cfg_byte_bus = 1'($urandom);
            cfg_muxed    = 1'($urandom);
            cfg_wr_bhe   = 1'($urandom);
            access(1'($urandom), 20'($urandom), 8'($urandom), int'($urandom % 4),
                   ($urandom % 8) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule